// File: doc/BRIEF.md
# Byte-Wide SPI Master with Slave-Side Transmit Request

This block is the single master on a four-wire SPI link to a host controller, which acts as the slave. It produces the serial clock by dividing the system clock and drives an active-low select. Each transfer is full duplex: one 8-bit byte goes out and one comes in. Only clock mode 0 is used, and bits travel least significant first in both directions.

Two things can start a transfer. The internal side can hand over a byte through a ready/valid handshake. The host can also pull an active-low request input low. After that input passes through a synchronizer, its falling edge makes the master run a dummy transfer that sends all zeros. This gives the host a slot to deliver a byte. Every received byte is presented with a one-cycle strobe and a flag that says which of the two sources started the transfer. Two rate-select inputs choose between a slow serial clock and a fast one (125 and 500 kbps in the intended system). The divider values are parameters.

Top module: `spi_req_master`

## Requirements
- R1: Clock mode 0. `sclk_o` is low whenever `cs_n_o` is high. `mosi_o` changes only while `sclk_o` is low, that is, on a falling edge. `miso_i` is sampled at each rising edge of `sclk_o`.
- R2: Bits are sent and received least significant bit first. Bit k of the byte is on the line during the (k+1)-th `sclk_o` pulse.
- R3: `cs_n_o` goes low for each transfer and stays low for exactly 8 `sclk_o` pulses. It is high while the block is idle and after reset, when `sclk_o` is 0, `tx_ready_o` is 1 and no strobes are active.
- R4: Each `sclk_o` half period lasts `DIV_FAST` system clocks when `rate_hi_i` is 1. Otherwise it lasts `DIV_SLOW` clocks. `rate_hi_i` wins when both inputs are high, and the slow rate is used when neither is high. The rate is captured when a transfer starts.
- R5: `tx_ready_o` is 1 only when the block is idle and no request is pending. A byte is taken on a clock where `tx_valid_i` and `tx_ready_o` are both 1. While the block is held off, the byte waiting on `tx_data_i` is neither taken nor lost, and it is sent unchanged later.
- R6: When a transfer started by a loaded byte ends, `tx_done_o` and `rx_valid_o` each pulse for one cycle together. At that point `rx_data_o` holds the received byte and `rx_from_req_o` is 0.
- R7: A falling edge on `treq_n_i` starts a dummy transfer after a two-flop synchronizer. The dummy transfer sends 0x00, and its end gives `rx_valid_o` with `rx_from_req_o` = 1 and no `tx_done_o`.
- R8: A request edge that arrives during a transfer is latched and served right after the current byte. `cs_n_o` returns high between the two bytes.
- R9: One falling edge gives exactly one dummy transfer. Holding `treq_n_i` low or releasing it high starts nothing more.
- R10: When a pending request and a waiting loaded byte compete, the dummy transfer goes first and the loaded byte follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_lo_i | input | 1 | Selects the slow bit rate |
| rate_hi_i | input | 1 | Selects the fast bit rate (wins over slow) |
| tx_valid_i | input | 1 | Internal side offers a byte |
| tx_data_i | input | DATA_W | Byte to send |
| tx_ready_o | output | 1 | Byte can be taken this cycle |
| tx_done_o | output | 1 | One-cycle pulse: loaded byte fully sent |
| rx_valid_o | output | 1 | One-cycle pulse: received byte ready |
| rx_data_o | output | DATA_W | Received byte |
| rx_from_req_o | output | 1 | Received byte came from a request-driven dummy transfer |
| treq_n_i | input | 1 | Asynchronous active-low transmit request from the host |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Active-low select |

## Verification
The bench aims at ordering conflicts. A request edge arrives while a byte is on the wire and a second byte is already waiting at the handshake. A design without the request latch would drop the dummy transfer. A design with the wrong priority would send the loaded byte first. A design that chained the two bytes would never raise select between them. The bench also holds the request low for a long time and then releases it, which exposes any design that reacts to a level or to a rising edge with extra transfers. Every rate-select combination is timed in system clocks, so a swapped divider or a wrong priority between the rate inputs shows up directly. Bit order is checked with asymmetric bytes on both lines, so a most-significant-first shift fails in both directions.

// File: rtl/spi_req_pkg.sv
// Shared types for the SPI master with transmit request.
package spi_req_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // select high, waiting for work
        ST_SHIFT = 2'd1,  // eight clock pulses in flight
        ST_TAIL  = 2'd2,  // last half period with clock low, select still low
        ST_GAP   = 2'd3   // select high for one half period before next byte
    } spi_st_t;
endpackage

// File: rtl/spi_req_edge.sv
// Synchronises the asynchronous active-low request input and emits a
// one-cycle pulse on each falling edge. Assumes the input is held for
// at least two system clocks at each level.
module spi_req_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_i,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift the raw input through the synchroniser chain; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], req_n_i};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign fall_o = last_q & ~sync_q[SYNC_STAGES-1];

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/spi_req_tick.sv
// Half-period tick generator for the serial clock. It counts while enabled
// and captures the rate selection while disabled, so the rate stays
// fixed for a whole transfer.
module spi_req_tick #(
    parameter int DIV_SLOW = 8,
    parameter int DIV_FAST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic rate_lo_i,
    input  logic rate_hi_i,
    output logic tick_o
);
    localparam int DMAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int CW   = $clog2(DMAX) + 1;

    logic [CW-1:0] div_q;
    logic [CW-1:0] cnt_q;
    logic          unused_lo;

    assign unused_lo = rate_lo_i;  // slow is also the default when neither is set

    // Capture the half-period length while idle; the fast rate wins.
    always_ff @(posedge clk) begin
        if (!rst_n)     div_q <= CW'(DIV_SLOW);
        else if (!en_i) div_q <= rate_hi_i ? CW'(DIV_FAST) : CW'(DIV_SLOW);
    end

    assign tick_o = en_i && (cnt_q == div_q - CW'(1));

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) cnt_q <= '0;
        else if (tick_o)     cnt_q <= '0;
        else                 cnt_q <= cnt_q + CW'(1);
    end

    p_div_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i)) |-> $stable(div_q));
endmodule

// File: rtl/spi_req_engine.sv
// Transfer sequencer. It owns the select, clock and data shift registers,
// the pending-request latch and the internal handshake. It assumes that
// tick_i pulses once per half period while busy_o is high.
module spi_req_engine
    import spi_req_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              req_fall_i,
    input  logic              tx_valid_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              tx_ready_o,
    output logic              busy_o,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              cs_n_o,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_from_req_o,
    output logic              tx_done_o
);
    localparam int BW = (DATA_W > 2) ? $clog2(DATA_W) : 1;

    spi_st_t           st_q;
    logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
    logic [BW-1:0]     bit_q;
    logic              pend_q, dummy_q;
    logic              start_req, start_load;

    assign busy_o     = (st_q != ST_IDLE);
    assign tx_ready_o = (st_q == ST_IDLE) && !pend_q;
    assign start_req  = (st_q == ST_IDLE) && pend_q;
    assign start_load = tx_ready_o && tx_valid_i;
    assign mosi_o     = tx_sh_q[0];

    // Latch request edges until a dummy transfer is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~start_req) | req_fall_i;
    end

    // Sequence select, clock and shifting; emit end-of-byte strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= ST_IDLE;
            tx_sh_q       <= '0;
            rx_sh_q       <= '0;
            bit_q         <= '0;
            sclk_o        <= 1'b0;
            cs_n_o        <= 1'b1;
            dummy_q       <= 1'b0;
            rx_valid_o    <= 1'b0;
            rx_data_o     <= '0;
            rx_from_req_o <= 1'b0;
            tx_done_o     <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            tx_done_o  <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_req || start_load) begin
                        tx_sh_q <= start_req ? '0 : tx_data_i;
                        dummy_q <= start_req;
                        bit_q   <= '0;
                        cs_n_o  <= 1'b0;
                        st_q    <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick_i && !sclk_o) begin
                        sclk_o  <= 1'b1;
                        rx_sh_q <= {miso_i, rx_sh_q[DATA_W-1:1]};
                    end else if (tick_i) begin
                        sclk_o <= 1'b0;
                        if (bit_q == BW'(DATA_W - 1)) begin
                            st_q <= ST_TAIL;
                        end else begin
                            bit_q   <= bit_q + BW'(1);
                            tx_sh_q <= tx_sh_q >> 1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick_i) begin
                        cs_n_o        <= 1'b1;
                        rx_valid_o    <= 1'b1;
                        rx_data_o     <= rx_sh_q;
                        rx_from_req_o <= dummy_q;
                        tx_done_o     <= !dummy_q;
                        st_q          <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tick_i) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    p_clk_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);
    p_mosi_hold_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
    p_ready_only_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> cs_n_o);
    p_done_with_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |-> (rx_valid_o && !rx_from_req_o));
    p_select_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |=> cs_n_o);
endmodule

// File: rtl/spi_req_master.sv
// Top level of the SPI master with host transmit request. It wires the
// request edge detector, the half-period tick generator and the transfer
// engine together. It assumes it is the only master on the link.
module spi_req_master #(
    parameter int DATA_W   = 8,
    parameter int DIV_SLOW = 8,
    parameter int DIV_FAST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_lo_i,
    input  logic              rate_hi_i,
    input  logic              tx_valid_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              tx_ready_o,
    output logic              tx_done_o,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_from_req_o,
    input  logic              treq_n_i,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              cs_n_o
);
    logic req_fall, tick, busy;

    spi_req_edge #(.SYNC_STAGES(2)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n_i (treq_n_i),
        .fall_o  (req_fall)
    );

    spi_req_tick #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (busy),
        .rate_lo_i (rate_lo_i),
        .rate_hi_i (rate_hi_i),
        .tick_o    (tick)
    );

    spi_req_engine #(.DATA_W(DATA_W)) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .req_fall_i    (req_fall),
        .tx_valid_i    (tx_valid_i),
        .tx_data_i     (tx_data_i),
        .tx_ready_o    (tx_ready_o),
        .busy_o        (busy),
        .miso_i        (miso_i),
        .sclk_o        (sclk_o),
        .mosi_o        (mosi_o),
        .cs_n_o        (cs_n_o),
        .rx_valid_o    (rx_valid_o),
        .rx_data_o     (rx_data_o),
        .rx_from_req_o (rx_from_req_o),
        .tx_done_o     (tx_done_o)
    );
endmodule

// File: tb/spi_req_master_tb.sv
// Directed bench: a behavioural slave model on the serial lines plus one
// task per scenario.
module spi_req_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DSLOW = 8;
    localparam int DFAST = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_lo = 1'b0, rate_hi = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready, tx_done, rx_valid, rx_from_req;
    logic [7:0] rx_data;
    logic       treq_n = 1'b1;
    logic       sclk, mosi, cs_n;
    logic       miso = 1'b0;

    spi_req_master #(.DATA_W(8), .DIV_SLOW(DSLOW), .DIV_FAST(DFAST)) u_dut (
        .clk(clk), .rst_n(rst_n), .rate_lo_i(rate_lo), .rate_hi_i(rate_hi),
        .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
        .tx_done_o(tx_done), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
        .rx_from_req_o(rx_from_req), .treq_n_i(treq_n), .sclk_o(sclk),
        .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    logic wd = 1'b0;

    // Slave model state.
    logic [7:0] slv_tx = 8'h00, slv_rx = 8'h00;
    int bitn = 0, pulses = 0, ntrans = 0;
    logic [7:0] log_mosi [0:31];
    int nlog = 0;
    // Strobe monitor state.
    int nrx = 0, ndone = 0;
    logic [7:0] last_rx = 8'h00;
    logic log_from [0:31];
    int hi_len = 0, last_hi = 0, err_mode = 0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Slave: load the first bit when select falls.
    always @(negedge cs_n) begin
        bitn = 0; pulses = 0; ntrans++;
        miso = slv_tx[0];
    end
    // Slave: sample the master output on the rising clock.
    always @(posedge sclk) begin
        if (bitn < 8) slv_rx[bitn] = mosi;
        pulses++;
    end
    // Slave: present the next bit on the falling clock.
    always @(negedge sclk) begin
        bitn++;
        if (bitn < 8) miso = slv_tx[bitn];
    end
    // Slave: log each finished byte when select rises.
    always @(posedge cs_n) begin
        if (rst_n && nlog < 32) begin
            log_mosi[nlog] = slv_rx;
            nlog++;
        end
    end

    // Monitor between clock edges: strobes, clock high width, mode 0 rules.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) wd = 1'b1;
        if (rst_n) begin
            if (rx_valid) begin
                last_rx = rx_data;
                if (nrx < 32) log_from[nrx] = rx_from_req;
                nrx++;
            end
            if (tx_done) ndone++;
            if (sclk) hi_len++;
            else if (hi_len != 0) begin last_hi = hi_len; hi_len = 0; end
            if (sclk && prev_sclk && mosi != prev_mosi) err_mode++;
            if (cs_n && sclk) err_mode++;
        end
        prev_sclk = sclk;
        prev_mosi = mosi;
    end

    task automatic wait_rx(input int target);
        while (nrx < target && !wd) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        tx_data  = b;
        tx_valid = 1'b1;
        while (!tx_ready && !wd) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic t_reset();
        check(cs_n == 1'b1, "R3 select high after reset", cs_n, 1);
        check(sclk == 1'b0, "R3 clock low after reset", sclk, 0);
        check(tx_ready == 1'b1, "R3 ready after reset", tx_ready, 1);
        check(rx_valid == 1'b0 && tx_done == 1'b0, "R3 no strobe after reset",
              {rx_valid, tx_done}, 0);
    endtask

    task automatic t_load(input logic [7:0] b, input logic [7:0] sb,
                          input logic lo, input logic hi, input int exp_hi);
        int r0 = nrx, d0 = ndone;
        rate_lo = lo; rate_hi = hi; slv_tx = sb;
        send_byte(b);
        wait_rx(r0 + 1);
        @(negedge clk);
        check(slv_rx == b, "R2 byte seen by slave", slv_rx, b);
        check(last_rx == sb, "R2 byte received from slave", last_rx, sb);
        check(pulses == 8, "R3 eight clock pulses", pulses, 8);
        check(last_hi == exp_hi, "R4 half period", last_hi, exp_hi);
        check(ndone == d0 + 1, "R6 done strobe", ndone, d0 + 1);
        check(log_from[r0] == 1'b0, "R6 not request flagged", log_from[r0], 0);
        check(cs_n == 1'b1, "R3 select high when idle", cs_n, 1);
    endtask

    task automatic t_req();
        int r0 = nrx, d0 = ndone;
        rate_lo = 1'b0; rate_hi = 1'b1; slv_tx = 8'hB4;
        treq_n = 1'b0;
        repeat (4) @(negedge clk);
        treq_n = 1'b1;
        wait_rx(r0 + 1);
        @(negedge clk);
        check(slv_rx == 8'h00, "R7 dummy sends zero", slv_rx, 0);
        check(last_rx == 8'hB4, "R7 host byte received", last_rx, 8'hB4);
        check(log_from[r0] == 1'b1, "R7 request flag", log_from[r0], 1);
        check(ndone == d0, "R7 no done strobe", ndone, d0);
    endtask

    task automatic t_req_held();
        int r0 = nrx, t0 = ntrans;
        slv_tx = 8'h3C;
        treq_n = 1'b0;
        wait_rx(r0 + 1);
        repeat (200) @(negedge clk);
        check(nrx == r0 + 1 && ntrans == t0 + 1, "R9 held low gives one transfer",
              ntrans - t0, 1);
        treq_n = 1'b1;
        repeat (200) @(negedge clk);
        check(ntrans == t0 + 1, "R9 release starts nothing", ntrans - t0, 1);
    endtask

    task automatic t_conflict();
        int r0 = nrx, t0 = ntrans, l0 = nlog, d0 = ndone;
        rate_lo = 1'b1; rate_hi = 1'b0; slv_tx = 8'h81;
        send_byte(8'h5A);
        while (cs_n && !wd) @(negedge clk);
        treq_n = 1'b0;
        repeat (4) @(negedge clk);
        treq_n = 1'b1;
        tx_data = 8'h96; tx_valid = 1'b1;
        @(negedge clk);
        check(tx_ready == 1'b0, "R5 held off while busy", tx_ready, 0);
        while (!tx_ready && !wd) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        tx_data  = 8'hFF;
        wait_rx(r0 + 3);
        @(negedge clk);
        check(ntrans == t0 + 3, "R8 select toggled per byte", ntrans - t0, 3);
        check(log_mosi[l0] == 8'h5A, "R8 first byte intact", log_mosi[l0], 8'h5A);
        check(log_mosi[l0+1] == 8'h00 && log_from[r0+1] == 1'b1,
              "R10 request served next", log_mosi[l0+1], 0);
        check(log_mosi[l0+2] == 8'h96 && log_from[r0+2] == 1'b0,
              "R5 waiting byte sent unchanged", log_mosi[l0+2], 8'h96);
        check(ndone == d0 + 2, "R6 done count", ndone - d0, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load(8'hA5, 8'h1E, 1'b0, 1'b1, DFAST);
        t_load(8'h01, 8'h80, 1'b1, 1'b0, DSLOW);
        t_load(8'hC8, 8'h37, 1'b1, 1'b1, DFAST);
        t_load(8'h6E, 8'hD2, 1'b0, 1'b0, DSLOW);
        t_req();
        t_req_held();
        t_conflict();
        check(err_mode == 0, "R1 mode 0 timing", err_mode, 0);
        check(!wd, "watchdog", wd, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule